// File: doc/BRIEF.md
# Differential Bit-Line Static RAM Array

This block is a behavioural model of a small static RAM array built from R rows and C columns. Each column carries a pair of bit lines, one true and one complement. Each row has a single select input. The array has no address or data port. An outside sequencer reaches the cells through the shared bit lines. It precharges both lines of every column high, releases them so that they float, raises one row select, and then either drives the lines to write or lets the selected cells pull them to read. The array only responds to this sequence and never generates it.

Every line and every cell holds one of four states: low, high, unknown or floating. These are carried as explicit two-bit codes, so unknown and floating survive any simulator. External drive is strong. A selected cell drives its lines weakly. A released line keeps its last resolved level as stored charge. When two or more selected cells disagree on a line, that line resolves to unknown, and every selected cell on it takes the unknown value at the next clock. A probe port shows the stored true and complement states of one row, so the cell contents can be observed directly.

Top module: `bl_diff_ram_array`

## Requirements
- R1: Every line or cell value is a two-bit code: low = 2'b00, high = 2'b01, unknown = 2'b10, floating = 2'b11. Column i uses bits [2i+1:2i] of every per-column bus, and word bit i belongs to column i. Cell (row, col) has flat index row*COLS+col.
- R2: After reset every cell reads unknown on the probe port. With no external drive and no row selected, every bit line reads floating.
- R3: A non-floating code driven externally onto a line appears on that line in the same cycle, whatever the selected cells hold.
- R4: A line with no external drive and no selected row keeps the value it resolved to on the previous cycle. After a precharge and release, both lines of every column read high.
- R5: At a rising clock edge with exactly one row selected, each cell of that row stores the resolved true and complement codes of its column. A written 1 is true = high and complement = low; a written 0 is the reverse.
- R6: With exactly one row selected and its lines undriven, each line shows that row's stored code in the same cycle, and the stored row does not change.
- R7: A row whose select is low neither drives its column lines nor changes its cells.
- R8: With several rows selected and the lines undriven, a line shows the common value of the selected cells when they agree and unknown when they differ.
- R9: A selected cell whose line resolves to unknown stores unknown at the next rising edge. A multi-row read of opposite data therefore turns both rows to unknown.
- R10: The probe row input selects a row, and the probe outputs show that row's stored true and complement codes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; cells and line charge update on the rising edge |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_sel_i | input | ROWS | Row select lines, one per row, active high |
| drv_t_i | input | 2*COLS | External drive code per true line (floating = not driven) |
| drv_c_i | input | 2*COLS | External drive code per complement line |
| probe_row_i | input | $clog2(ROWS) | Row whose stored states are shown on the probe outputs |
| bl_t_o | output | 2*COLS | Resolved code of every true bit line |
| bl_c_o | output | 2*COLS | Resolved code of every complement bit line |
| probe_t_o | output | 2*COLS | Stored true state of each cell in the probed row |
| probe_c_o | output | 2*COLS | Stored complement state of each cell in the probed row |

## Verification
A cell that is stored wrongly stays invisible on the bit lines until its row is next selected with the lines floating. At that point the bad code appears on the lines in the same cycle as the select, and the probe port shows it as soon as the row is addressed. A defect in the line charge shows on the first idle cycle after a precharge, when released lines fail to read high. A resolver that does not merge drivers correctly shows within the selecting cycle of a multi-row access: the lines read a plain level where unknown is expected. One clock later, the probe shows cells that kept their data instead of becoming unknown.

// File: rtl/bl_ram_pkg.sv
`timescale 1ns/1ps
package bl_ram_pkg;

  // Four-state level code carried on every line and in every cell.
  typedef enum logic [1:0] {
    LV_LO = 2'b00,
    LV_HI = 2'b01,
    LV_X  = 2'b10,
    LV_Z  = 2'b11
  } lv_e;

  localparam int unsigned LV_W = 2;

  // Merge of two weak drivers on one line.
  function automatic logic [1:0] lv_merge(input logic [1:0] a, input logic [1:0] b);
    if (a == b) return a;
    return LV_X;
  endfunction

endpackage

// File: rtl/bl_rst_sync.sv
`timescale 1ns/1ps
module bl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/bl_line_resolve.sv
`timescale 1ns/1ps
module bl_line_resolve
  import bl_ram_pkg::*;
#(
  parameter int unsigned ROWS = 4
) (
  input  logic [1:0]        ext_i,
  input  logic [ROWS-1:0]   sel_i,
  input  logic [2*ROWS-1:0] cell_i,
  input  logic [1:0]        charge_i,
  output logic [1:0]        line_o
);

  logic       hit;
  logic [1:0] agg;

  // Weak drive from selected cells; disagreement gives unknown.
  always_comb begin
    hit = 1'b0;
    agg = LV_Z;
    for (int r = 0; r < int'(ROWS); r++) begin
      if (sel_i[r]) begin
        if (!hit) begin
          agg = cell_i[2*r +: 2];
        end else begin
          agg = lv_merge(agg, cell_i[2*r +: 2]);
        end
        hit = 1'b1;
      end
    end
  end

  // Strong external drive, then weak cell drive, then held charge.
  always_comb begin
    if (ext_i != LV_Z) begin
      line_o = ext_i;
    end else if (hit) begin
      line_o = agg;
    end else begin
      line_o = charge_i;
    end
  end

endmodule

// File: rtl/bl_line_keeper.sv
`timescale 1ns/1ps
module bl_line_keeper
  import bl_ram_pkg::*;
#(
  parameter int unsigned LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*LINES-1:0] line_i,
  output logic [2*LINES-1:0] charge_o
);

  logic [2*LINES-1:0] charge_q;
  logic [2*LINES-1:0] charge_d;
  logic [LINES-1:0]   upd;

  for (genvar i = 0; i < LINES; i++) begin : g_upd
    assign upd[i] = (line_i[2*i +: 2] != charge_q[2*i +: 2]);
  end

  always_comb begin
    charge_d = charge_q;
    for (int i = 0; i < int'(LINES); i++) begin
      if (upd[i]) begin
        charge_d[2*i +: 2] = line_i[2*i +: 2];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      charge_q <= {LINES{LV_Z}};
    end else begin
      charge_q <= charge_d;
    end
  end

  assign charge_o = charge_q;

endmodule

// File: rtl/bl_cell_store.sv
`timescale 1ns/1ps
module bl_cell_store
  import bl_ram_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ROWS-1:0]        sel_i,
  input  logic [2*COLS-1:0]      bl_t_i,
  input  logic [2*COLS-1:0]      bl_c_i,
  output logic [2*ROWS*COLS-1:0] cell_t_o,
  output logic [2*ROWS*COLS-1:0] cell_c_o
);

  localparam int unsigned ROW_W = 2 * COLS;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic             row_en;
    logic [ROW_W-1:0] t_q, t_d;
    logic [ROW_W-1:0] c_q, c_d;

    assign row_en = sel_i[r];

    always_comb begin
      t_d = t_q;
      c_d = c_q;
      if (row_en) begin
        t_d = bl_t_i;
        c_d = bl_c_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        t_q <= {COLS{LV_X}};
        c_q <= {COLS{LV_X}};
      end else begin
        t_q <= t_d;
        c_q <= c_d;
      end
    end

    // Flat cell index is row*COLS+col.
    assign cell_t_o[r*ROW_W +: ROW_W] = t_q;
    assign cell_c_o[r*ROW_W +: ROW_W] = c_q;
  end

endmodule

// File: rtl/bl_diff_ram_array.sv
`timescale 1ns/1ps
module bl_diff_ram_array
  import bl_ram_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8,
  localparam int unsigned RW  = $clog2(ROWS),
  localparam int unsigned BW  = 2 * COLS
) (
  input  logic            clk_i,
  input  logic            arst_ni,
  input  logic [ROWS-1:0] row_sel_i,
  input  logic [BW-1:0]   drv_t_i,
  input  logic [BW-1:0]   drv_c_i,
  input  logic [RW-1:0]   probe_row_i,
  output logic [BW-1:0]   bl_t_o,
  output logic [BW-1:0]   bl_c_o,
  output logic [BW-1:0]   probe_t_o,
  output logic [BW-1:0]   probe_c_o
);

  localparam int unsigned CELLS_W = 2 * ROWS * COLS;

  if (ROWS < 2 || COLS > 32) begin : g_bad_size
    $error("bl_diff_ram_array needs ROWS >= 2 and COLS <= 32");
  end

  logic               rst_sync_n;
  logic [CELLS_W-1:0] cell_t;
  logic [CELLS_W-1:0] cell_c;
  logic [2*BW-1:0]    charge;
  logic [BW-1:0]      bl_t;
  logic [BW-1:0]      bl_c;

  bl_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_sync_n)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [2*ROWS-1:0] col_t;
    logic [2*ROWS-1:0] col_c;

    for (genvar r = 0; r < ROWS; r++) begin : g_tap
      assign col_t[2*r +: 2] = cell_t[2*(r*COLS+c) +: 2];
      assign col_c[2*r +: 2] = cell_c[2*(r*COLS+c) +: 2];
    end

    bl_line_resolve #(.ROWS(ROWS)) u_res_t (
      .ext_i    (drv_t_i[2*c +: 2]),
      .sel_i    (row_sel_i),
      .cell_i   (col_t),
      .charge_i (charge[2*c +: 2]),
      .line_o   (bl_t[2*c +: 2])
    );

    bl_line_resolve #(.ROWS(ROWS)) u_res_c (
      .ext_i    (drv_c_i[2*c +: 2]),
      .sel_i    (row_sel_i),
      .cell_i   (col_c),
      .charge_i (charge[BW + 2*c +: 2]),
      .line_o   (bl_c[2*c +: 2])
    );
  end

  bl_line_keeper #(.LINES(2*COLS)) u_keep (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .line_i   ({bl_c, bl_t}),
    .charge_o (charge)
  );

  bl_cell_store #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sel_i    (row_sel_i),
    .bl_t_i   (bl_t),
    .bl_c_i   (bl_c),
    .cell_t_o (cell_t),
    .cell_c_o (cell_c)
  );

  always_comb begin
    probe_t_o = {COLS{LV_X}};
    probe_c_o = {COLS{LV_X}};
    for (int r = 0; r < int'(ROWS); r++) begin
      if (probe_row_i == RW'(r)) begin
        probe_t_o = cell_t[r*BW +: BW];
        probe_c_o = cell_c[r*BW +: BW];
      end
    end
  end

  assign bl_t_o = bl_t;
  assign bl_c_o = bl_c;

endmodule

// File: rtl/bl_ram_array_chk.sv
`timescale 1ns/1ps
module bl_ram_array_chk
  import bl_ram_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ROWS-1:0]        sel,
  input logic [2*COLS-1:0]      ext_t,
  input logic [2*COLS-1:0]      ext_c,
  input logic [2*COLS-1:0]      bl_t,
  input logic [2*ROWS*COLS-1:0] cell_t
);

  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_c
    // R3: strong drive wins
    p_ext_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_t[2*c +: 2] != LV_Z) |-> (bl_t[2*c +: 2] == ext_t[2*c +: 2]));

    // R4: an idle line keeps its level
    p_float_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && ext_t[2*c +: 2] == LV_Z && sel == '0) |-> $stable(bl_t[2*c +: 2]));

    // R8: opposite data on rows 0 and 1 gives unknown
    p_multi_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[0] && sel[1] && ext_t[2*c +: 2] == LV_Z &&
       cell_t[2*c +: 2] != cell_t[2*(COLS+c) +: 2]) |-> (bl_t[2*c +: 2] == LV_X));

    for (genvar r = 0; r < ROWS; r++) begin : g_r
      // R5: a single-row write captures the driven code
      p_write_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sel) == 1 && sel[r] && ext_t[2*c +: 2] != LV_Z && ext_c[2*c +: 2] != LV_Z)
        |=> (cell_t[2*(r*COLS+c) +: 2] == $past(ext_t[2*c +: 2])));

      // R6: a single-row read shows the stored code
      p_read_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sel) == 1 && sel[r] && ext_t[2*c +: 2] == LV_Z)
        |-> (bl_t[2*c +: 2] == cell_t[2*(r*COLS+c) +: 2]));

      // R7: an unselected cell keeps its state
      p_idle_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel[r]) |=> $stable(cell_t[2*(r*COLS+c) +: 2]));

      // R9: unknown on the line corrupts the selected cell
      p_conflict_cell_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[r] && bl_t[2*c +: 2] == LV_X) |=> (cell_t[2*(r*COLS+c) +: 2] == LV_X));
    end
  end

endmodule

bind bl_diff_ram_array bl_ram_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .sel    (row_sel_i),
  .ext_t  (drv_t_i),
  .ext_c  (drv_c_i),
  .bl_t   (bl_t),
  .cell_t (cell_t)
);

// File: tb/tb_bl_diff_ram_array.sv
`timescale 1ns/1ps
module tb_bl_diff_ram_array;

  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int BW   = 2 * COLS;
  localparam int NVEC = 9;

  localparam logic [1:0] C_LO = 2'b00;
  localparam logic [1:0] C_HI = 2'b01;
  localparam logic [1:0] C_X  = 2'b10;
  localparam logic [1:0] C_Z  = 2'b11;

  // {write[15], row[11:8], data[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h8000, 16'h81FF, 16'h0000, 16'h01FF,
    16'h82A5, 16'h02A5, 16'h833C, 16'h033C, 16'h0000
  };

  logic            clk;
  logic            arst_n;
  logic [ROWS-1:0] sel;
  logic [BW-1:0]   drv_t, drv_c;
  logic [1:0]      probe_row;
  logic [BW-1:0]   bl_t, bl_c, probe_t, probe_c;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bl_diff_ram_array #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk_i       (clk),
    .arst_ni     (arst_n),
    .row_sel_i   (sel),
    .drv_t_i     (drv_t),
    .drv_c_i     (drv_c),
    .probe_row_i (probe_row),
    .bl_t_o      (bl_t),
    .bl_c_o      (bl_c),
    .probe_t_o   (probe_t),
    .probe_c_o   (probe_c)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [BW-1:0] fill(input logic [1:0] code);
    return {COLS{code}};
  endfunction

  function automatic logic [BW-1:0] enc_t(input logic [COLS-1:0] d);
    logic [BW-1:0] v;
    for (int i = 0; i < COLS; i++) v[2*i +: 2] = d[i] ? C_HI : C_LO;
    return v;
  endfunction

  function automatic logic [BW-1:0] enc_c(input logic [COLS-1:0] d);
    return enc_t(~d);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic precharge();
    sel   = '0;
    drv_t = fill(C_HI);
    drv_c = fill(C_HI);
    @(negedge clk);
    drv_t = fill(C_Z);
    drv_c = fill(C_Z);
    #1;
    chk("R4 true after release", 64'(bl_t), 64'(fill(C_HI)));
    chk("R4 comp after release", 64'(bl_c), 64'(fill(C_HI)));
    @(negedge clk);
  endtask

  task automatic access(input bit wr, input int row, input logic [COLS-1:0] d);
    precharge();
    sel = ROWS'(1) << row;
    if (wr) begin
      drv_t = enc_t(d);
      drv_c = enc_c(d);
    end
    #1;
    if (!wr) begin
      chk("R6 read true", 64'(bl_t), 64'(enc_t(d)));
      chk("R6 read comp", 64'(bl_c), 64'(enc_c(d)));
    end
    @(negedge clk);
    sel       = '0;
    drv_t     = fill(C_Z);
    drv_c     = fill(C_Z);
    probe_row = 2'(row);
    #1;
    chk(wr ? "R5 stored true" : "R6 row kept true", 64'(probe_t), 64'(enc_t(d)));
    chk(wr ? "R5 stored comp" : "R6 row kept comp", 64'(probe_c), 64'(enc_c(d)));
    @(negedge clk);
  endtask

  initial begin
    arst_n    = 1'b0;
    sel       = '0;
    drv_t     = fill(C_Z);
    drv_c     = fill(C_Z);
    probe_row = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reset state
    #1;
    chk("R2 lines floating", 64'(bl_t), 64'(fill(C_Z)));
    chk("R2 cells unknown", 64'(probe_t), 64'(fill(C_X)));
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      access(VEC[k][15], int'(VEC[k][11:8]), VEC[k][7:0]);
    end

    // R1 and R10: field layout of row 3 (3C) on the probe
    probe_row = 2'd3;
    #1;
    chk("R1 col0 low", 64'(probe_t[1:0]), 64'(C_LO));
    chk("R1 col2 high", 64'(probe_t[5:4]), 64'(C_HI));
    chk("R10 probe row3", 64'(probe_c), 64'(enc_c(8'h3C)));
    @(negedge clk);

    // R3: external drive overrides a reading cell, then is withdrawn before any edge
    precharge();
    sel          = 4'b0010;
    drv_t[1:0]   = C_LO;
    #1;
    chk("R3 driven col0", 64'(bl_t[1:0]), 64'(C_LO));
    chk("R3 cell col1", 64'(bl_t[3:2]), 64'(C_HI));
    #1;
    sel   = '0;
    drv_t = fill(C_Z);
    @(negedge clk);
    probe_row = 2'd1;
    #1;
    chk("R7 row1 intact", 64'(probe_t), 64'(enc_t(8'hFF)));
    @(negedge clk);

    // R8: two rows with equal data
    access(1'b1, 3, 8'hA5);
    precharge();
    sel = 4'b1100;
    #1;
    chk("R8 agree true", 64'(bl_t), 64'(enc_t(8'hA5)));
    chk("R8 agree comp", 64'(bl_c), 64'(enc_c(8'hA5)));
    @(negedge clk);
    sel       = '0;
    probe_row = 2'd2;
    #1;
    chk("R8 agree row2 kept", 64'(probe_t), 64'(enc_t(8'hA5)));
    @(negedge clk);

    // R8 / R9: rows 0 and 1 hold opposite data
    precharge();
    sel = 4'b0011;
    #1;
    chk("R8 conflict true", 64'(bl_t), 64'(fill(C_X)));
    chk("R8 conflict comp", 64'(bl_c), 64'(fill(C_X)));
    @(negedge clk);
    sel       = '0;
    probe_row = 2'd0;
    #1;
    chk("R9 row0 true", 64'(probe_t), 64'(fill(C_X)));
    chk("R9 row0 comp", 64'(probe_c), 64'(fill(C_X)));
    probe_row = 2'd1;
    #1;
    chk("R9 row1 true", 64'(probe_t), 64'(fill(C_X)));
    chk("R9 row1 comp", 64'(probe_c), 64'(fill(C_X)));
    probe_row = 2'd2;
    #1;
    chk("R7 row2 untouched", 64'(probe_t), 64'(enc_t(8'hA5)));
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule